// File: doc/BRIEF.md
# Real-Time Clock Divider and Update-Cycle Controller

This block is the timebase of a PC-style CMOS real-time clock. It runs from the 32.768 kHz oscillator clock and divides it down to one "advance seconds" strobe per second. The calendar logic that counts seconds, minutes and days sits outside this block and consumes that strobe. Before each strobe the block raises an update-in-progress flag for a short window, so that software knows not to read the time registers. On each one-second boundary it also sets an update-ended flag, which can raise an interrupt request.

A small register port with three addressed registers controls the block. The control register selects the divider mode, holds a rate field that is stored only, and shows the update-in-progress flag. The mode register carries the time-freeze bit and the update-ended interrupt enable. The flag register reports the update-ended event and clears when it is read.

One divider code holds the divider chain in reset. While it is held, nothing advances and no interrupt is raised. When the chain is released to a running code, the first strobe comes half a second later. The time-freeze bit behaves differently: it stops the seconds strobe, but the divider keeps its phase and update-ended events still occur.

Top module: `rtc_timebase`

## Requirements
- R1: After reset, register A (address 0) reads 0x20, register B (address 1) reads 0x00, register C (address 2) reads 0x00, address 3 reads 0x00, and both `irq` and `secStrobe` are 0.
- R2: Register A bits 6:4 form the divider field. Codes 000, 001 and 010 run the divider chain. With the time-freeze bit at 0, `secStrobe` pulses for one cycle every 32768 clocks.
- R3: A divider field whose bits 6 and 5 are both 1 holds the chain. While it is held, `secStrobe` stays 0, UIP stays 0, and the update-ended flag is not set.
- R4: A write to register A that moves the divider field from a hold code to a running code makes the first `secStrobe` appear 16384 clocks after that write's clock edge.
- R5: The update-in-progress flag (register A bit 7) rises 8 clocks before each `secStrobe` and reads 0 in the cycle of the strobe. It is raised only while the time-freeze bit is 0.
- R6: Register A bit 7 cannot be written. A write stores bits 6:0 and leaves the flag unchanged.
- R7: While the time-freeze bit (register B bit 7) is 1, no `secStrobe` is produced. The update-ended flag (register C bit 4) is still set at each one-second boundary.
- R8: Any write to register B with bit 7 set forces the interrupt enable (register B bit 4) to 0. Register B bits other than 7 and 4 read 0.
- R9: Setting and then clearing the time-freeze bit does not restart the sub-second phase. The next strobe stays 32768 clocks after the previous one.
- R10: Each one-second boundary sets register C bit 4. `irq` and register C bit 7 equal bit 4 AND the interrupt enable. A read strobe on register C clears bit 4, and writes to register C have no effect.
- R11: The update-in-progress flag is cleared by the write that enters the hold code and by the write that releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select: 0 = A, 1 = B, 2 = C |
| regWr | input | 1 | Write strobe, sampled on the clock edge |
| regRd | input | 1 | Read strobe; on register C it clears the flags |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for `regAddr` |
| secStrobe | output | 1 | One-cycle advance-seconds pulse |
| irq | output | 1 | Update-ended interrupt request |

## Verification
Register contents appear on `regRdata` combinationally, so the bench samples a register immediately after the edge that wrote it. `secStrobe`, the update-ended flag and the update-in-progress flag are registered. Each one changes on the clock edge where the divider count reaches its terminal or pre-terminal value. The bench numbers every rising edge and samples on the falling edge, so a strobe that follows a write at edge W is expected at exactly W+16384, and one that follows a strobe at edge S is expected at S+32768. The update-in-progress flag must first read 1 at S+32760. The read-to-clear of register C takes effect on the edge that samples the read strobe, and the bench checks the cleared value only after that edge.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;

  localparam logic [1:0] ADDR_A = 2'd0;
  localparam logic [1:0] ADDR_B = 2'd1;
  localparam logic [1:0] ADDR_C = 2'd2;

  localparam int A_UIP  = 7;
  localparam int B_SET  = 7;
  localparam int B_UIE  = 4;
  localparam int C_IRQF = 7;
  localparam int C_UF   = 4;

  localparam logic [2:0] DIV_RESET_VAL = 3'b010;
  localparam logic [2:0] DIV_RUN_MAX   = 3'b010;

  // strobes from control to datapath
  typedef struct packed {
    logic chainRun;  // divider field selects a running code
    logic advEn;     // time-freeze bit is clear
    logic loadHalf;  // release from hold: preload half-second phase
    logic clrUip;    // hold entry or release write
  } tbCtrl_t;

endpackage

// File: rtl/rtc_tb_ctrl.sv
module rtc_tb_ctrl
  import rtc_timebase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  input  logic       tick,
  input  logic       uip,
  output tbCtrl_t    ctrl,
  output logic [7:0] regRdata,
  output logic       irq,
  output logic [2:0] divSel,
  output logic       setBit,
  output logic       uieBit,
  output logic       ufBit
);

  logic [3:0] rateSel;
  logic wrA, wrB, rdC;
  logic heldNow, heldNew, runNew;

  assign wrA = regWr && (regAddr == ADDR_A);
  assign wrB = regWr && (regAddr == ADDR_B);
  assign rdC = regRd && (regAddr == ADDR_C);

  assign heldNow = (divSel[2:1] == 2'b11);
  assign heldNew = (regWdata[6:5] == 2'b11);
  assign runNew  = (regWdata[6:4] <= DIV_RUN_MAX);

  always_comb begin
    ctrl.chainRun = (divSel <= DIV_RUN_MAX);
    ctrl.advEn    = !setBit;
    ctrl.loadHalf = wrA && heldNow && runNew;
    ctrl.clrUip   = wrA && (heldNew || (heldNow && runNew));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSel  <= DIV_RESET_VAL;
      rateSel <= '0;
    end else if (wrA) begin
      divSel  <= regWdata[6:4];
      rateSel <= regWdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setBit <= 1'b0;
      uieBit <= 1'b0;
    end else if (wrB) begin
      setBit <= regWdata[B_SET];
      uieBit <= regWdata[B_UIE] & ~regWdata[B_SET];
    end
  end

  // a boundary in the same cycle as a clearing read wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ufBit <= 1'b0;
    else if (tick)  ufBit <= 1'b1;
    else if (rdC)   ufBit <= 1'b0;
  end

  assign irq = ufBit & uieBit;

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_A: regRdata = {uip, divSel, rateSel};
      ADDR_B: begin
        regRdata[B_SET] = setBit;
        regRdata[B_UIE] = uieBit;
      end
      ADDR_C: begin
        regRdata[C_IRQF] = irq;
        regRdata[C_UF]   = ufBit;
      end
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_tb_dpath.sv
module rtc_tb_dpath
  import rtc_timebase_pkg::*;
#(
  parameter int PHASE_W  = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  tbCtrl_t ctrl,
  output logic    tick,
  output logic    uip,
  output logic    secStrobe
);

  localparam logic [PHASE_W-1:0] PHASE_MAX = {PHASE_W{1'b1}};
  localparam logic [PHASE_W-1:0] PHASE_HALF = {1'b1, {(PHASE_W-1){1'b0}}};
  localparam logic [PHASE_W-1:0] UIP_AT = PHASE_MAX - PHASE_W'(UIP_LEAD);

  logic [PHASE_W-1:0] phase;
  logic uipStart;

  assign tick     = ctrl.chainRun && (phase == PHASE_MAX);
  assign uipStart = ctrl.chainRun && ctrl.advEn && (phase == UIP_AT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phase <= '0;
    else if (ctrl.loadHalf) phase <= PHASE_HALF;
    else if (ctrl.chainRun) phase <= phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     uip <= 1'b0;
    else if (ctrl.clrUip || tick)  uip <= 1'b0;
    else if (uipStart)             uip <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) secStrobe <= 1'b0;
    else       secStrobe <= tick && ctrl.advEn;
  end

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_timebase_pkg::*;
#(
  parameter int PHASE_W  = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       secStrobe,
  output logic       irq
);

  tbCtrl_t    ctrl;
  logic       tick;
  logic       uip;
  logic [2:0] divSel;
  logic       setBit;
  logic       uieBit;
  logic       ufBit;

  rtc_tb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .regWdata (regWdata),
    .tick     (tick),
    .uip      (uip),
    .ctrl     (ctrl),
    .regRdata (regRdata),
    .irq      (irq),
    .divSel   (divSel),
    .setBit   (setBit),
    .uieBit   (uieBit),
    .ufBit    (ufBit)
  );

  rtc_tb_dpath #(
    .PHASE_W  (PHASE_W),
    .UIP_LEAD (UIP_LEAD)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .tick      (tick),
    .uip       (uip),
    .secStrobe (secStrobe)
  );

endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk (
  input logic       clk,
  input logic       rstN,
  input logic       secStrobe,
  input logic       uip,
  input logic [2:0] divSel,
  input logic       setBit,
  input logic       uieBit,
  input logic       ufBit
);

  logic held;
  assign held = (divSel[2:1] == 2'b11);

  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    secStrobe |=> !secStrobe);

  p_hold_no_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    secStrobe |-> !$past(held));

  p_hold_no_uip_r11: assert property (@(posedge clk) disable iff (!rstN)
    held |-> !uip);

  p_strobe_uip_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    secStrobe |-> !uip);

  p_set_no_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    secStrobe |-> !$past(setBit));

  p_set_kills_uie_r8: assert property (@(posedge clk) disable iff (!rstN)
    setBit |-> !uieBit);

  p_strobe_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    secStrobe |-> ufBit);

endmodule

bind rtc_timebase rtc_timebase_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .secStrobe (secStrobe),
  .uip       (uip),
  .divSel    (divSel),
  .setBit    (setBit),
  .uieBit    (uieBit),
  .ufBit     (ufBit)
);

// File: tb/sim_rtc_timebase.sv
module sim_rtc_timebase;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       secStrobe;
  logic       irq;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int lastEdge = 0;
  bit finished = 1'b0;

  // {addr, write data, expected readback}
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 8'hA5, 8'h25},
    {2'd0, 8'h0A, 8'h0A},
    {2'd0, 8'hA0, 8'h20},
    {2'd1, 8'h10, 8'h10},
    {2'd1, 8'h90, 8'h80},
    {2'd1, 8'h7F, 8'h10},
    {2'd2, 8'hFF, 8'h00},
    {2'd1, 8'h00, 8'h00}
  };

  rtc_timebase u0 (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .secStrobe (secStrobe),
    .irq       (irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regAddr = 2'd0;
    lastEdge = cyc;
  endtask

  task automatic rdClearC(output logic [7:0] v);
    @(negedge clk);
    regAddr = 2'd2; regRd = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0; regAddr = 2'd0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    regAddr = a;
    #1 v = regRdata;
    regAddr = 2'd0;
    #1;
  endtask

  // waits for a strobe; also records the first cycle UIP reads 1
  task automatic waitStrobe(input int limit, output int at, output int uipAt, output logic uipAtStrobe);
    at = -1; uipAt = -1; uipAtStrobe = 1'bx;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (secStrobe) begin
        at = cyc; uipAtStrobe = regRdata[7];
        break;
      end
      if (regRdata[7] && uipAt < 0) uipAt = cyc;
    end
  endtask

  initial begin
    wait (cyc >= 199000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int s1, s2, s3, u, ns, nu, w;
    logic uipS;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    peek(2'd0, v); check("R1 reg A", v, 8'h20);
    peek(2'd1, v); check("R1 reg B", v, 8'h00);
    peek(2'd2, v); check("R1 reg C", v, 8'h00);
    peek(2'd3, v); check("R1 addr 3", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 secStrobe", secStrobe, 0);

    // table: R6 A bit7 read-only, R8 SET clears UIE, R10 C not writable, R2 field store
    for (int i = 0; i < 8; i++) begin
      wrReg(VEC[i][17:16], VEC[i][15:8]);
      peek(VEC[i][17:16], v);
      check($sformatf("R6 R8 R10 table vector %0d", i), v, VEC[i][7:0]);
    end
    check("R10 irq idle", irq, 0);

    // first strobe, then update-ended flag and interrupt
    waitStrobe(40000, s1, u, uipS);
    check("R2 strobe seen", (s1 > 0), 1);
    peek(2'd2, v); check("R10 UF after strobe", v, 8'h10);
    check("R10 irq with UIE off", irq, 0);
    @(negedge clk);
    check("R2 strobe one cycle", secStrobe, 0);
    wrReg(2'd1, 8'h10);
    check("R10 irq with UIE on", irq, 1);
    rdClearC(v);
    check("R10 C read value", v, 8'h90);
    check("R10 irq after clear", irq, 0);
    peek(2'd2, v); check("R10 C cleared", v, 8'h00);
    wrReg(2'd1, 8'h00);

    // UIP rises 8 before boundary; enter hold inside that window
    u = -1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (regRdata[7]) begin u = cyc; break; end
    end
    check("R5 UIP lead from strobe", u - s1, 32760);
    wrReg(2'd0, 8'h60);
    peek(2'd0, v); check("R11 UIP cleared on hold entry", v, 8'h60);
    ns = 0; nu = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (secStrobe) ns++;
      if (regRdata[7]) nu++;
    end
    check("R3 no strobe in hold", ns, 0);
    check("R3 no UIP in hold", nu, 0);
    peek(2'd2, v); check("R3 no UF in hold", v, 8'h00);

    // release: half second to first strobe
    wrReg(2'd0, 8'h20);
    w = lastEdge;
    peek(2'd0, v); check("R11 UIP clear after release", v, 8'h20);
    waitStrobe(20000, s2, u, uipS);
    check("R4 release to first strobe", s2 - w, 16384);

    // R9: toggle SET early in the second; phase must be kept
    wrReg(2'd1, 8'h80);
    wrReg(2'd1, 8'h00);
    waitStrobe(40000, s3, u, uipS);
    check("R2 R9 strobe period", s3 - s2, 32768);
    check("R5 UIP rise point", u - s2, 32760);
    check("R5 UIP low at strobe", uipS, 0);
    peek(2'd2, v); check("R10 UF set again", v, 8'h10);
    rdClearC(v);

    // R7: frozen time, UF still set at the boundary
    wrReg(2'd1, 8'h80);
    ns = 0; nu = 0;
    while (cyc < s3 + 32772) begin
      @(negedge clk);
      if (secStrobe) ns++;
      if (regRdata[7]) nu++;
    end
    check("R7 no strobe while frozen", ns, 0);
    check("R5 no UIP while frozen", nu, 0);
    peek(2'd2, v); check("R7 UF set while frozen", v, 8'h10);
    peek(2'd1, v); check("R8 B while frozen", v, 8'h80);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule